// File: doc/BRIEF.md
# Accelerator Launch and Interrupt Register File

This block is the software-facing control point of a frame-processing core. A host reaches it through a simple strobe bus: one write or one read per cycle, no wait states. Read data and its valid flag come back the cycle after the read strobe. The block keeps a control word and drives a level start request to the core. The core answers with one-cycle pulses when it has taken its inputs (ready) and when it has finished a transaction (done). From these the register file tracks launch, completion, idle and ready state. It can relaunch the core on its own after every transaction.

Two event channels, done and ready, feed a small interrupt unit. Each channel has an enable bit and a sticky status bit that software clears by writing 1 to toggle it. One global enable gates the single interrupt line. The block also holds ten 16-bit frame parameter words (size, format, window bounds, fill components). The core reads these words directly; the register file only stores them.

The bus carries no back-pressure. Every strobe is accepted in the cycle it is seen, and a read always answers exactly one cycle later.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset the control word at 0x000 reads 0x04 (only idle set). The registers at 0x004, 0x008, 0x00C and every parameter word read 0, and irq and core_start are low.
- R2: Writing a 1 to bit 0 of 0x000 raises core_start on the next cycle. core_start stays high until a core_ready pulse and is low the cycle after that pulse. Writing 0 to bit 0 does not clear it.
- R3: A core_done pulse sets bit 1 of 0x000. A read of 0x000 returns the bit and then clears it. If a core_done pulse arrives in the same cycle as that read, the bit stays set for the next read.
- R4: Bit 2 of 0x000 (idle) drops to 0 the cycle after any launch. It returns to 1 after a core_done pulse when no launch is pending or triggered.
- R5: Bit 3 of 0x000 (ready) is set by a core_ready pulse and cleared by the next launch.
- R6: Bit 7 of 0x000 is a read/write auto-relaunch flag. While it is 1, every core_done pulse raises core_start on the next cycle without a bus write.
- R7: Bit 0 of 0x004 is the global interrupt enable. Bits 1:0 of 0x008 are the channel enables (bit 0 done, bit 1 ready). Both are read/write, and all their other bits read 0.
- R8: A core_done pulse sets status bit 0 of 0x00C, and a core_ready pulse sets status bit 1, each only while its channel enable is 1. An event on a disabled channel leaves its status bit unchanged.
- R9: Writing 1 to a bit of 0x00C toggles that status bit, and writing 0 leaves it unchanged. If a set event and a toggle hit the same bit in one cycle, the bit ends up 1.
- R10: irq is high exactly when the global enable is 1 and at least one status bit is 1.
- R11: The ten parameter words at 0x010 + 8k (k = 0..9) store bits 15:0 of a write, and their bits 31:16 read 0.
- R12: Every other offset (including 0x014, 0x05C and 0x060) reads 0, and writes to it change no register.
- R13: bus_rd_valid is high, with bus_rdata, exactly one cycle after bus_rd_en, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered |
| bus_rd_valid | output | 1 | Marks bus_rdata valid, one cycle after bus_rd_en |
| core_start | output | 1 | Start request level to the core |
| core_ready | input | 1 | Core pulse: start taken, inputs read |
| core_done | input | 1 | Core pulse: transaction complete |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle. A done pulse can meet a clear-on-read of the control word, and a channel event can meet a toggle write to the same status bit. The bench drives the pulse and the bus strobe on the same falling edge. It then reads back: the read that raced the pulse must show done as 0 and the next read must show it as 1, and a status bit already at 1 must still be 1 after the toggle that met its set event. Auto-relaunch is judged the same way, by a done pulse that must raise core_start on the next cycle with no write in between.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;

  // Register offsets (byte addresses)
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_GIE  = 'h04;
  localparam int OFS_IER  = 'h08;
  localparam int OFS_ISR  = 'h0C;

  // Parameter word placement
  localparam int PARAM_BASE   = 'h10;
  localparam int PARAM_STRIDE = 8;

  // Control word bit positions
  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IDLE  = 2;
  localparam int CB_READY = 3;
  localparam int CB_AUTO  = 7;

  // Interrupt channel indices
  localparam int CH_DONE  = 0;
  localparam int CH_READY = 1;

  typedef struct packed {
    logic auto_rs;
    logic ready;
    logic idle;
    logic done;
    logic start;
  } ctl_state_t;

endpackage

// File: rtl/accel_ctl_handshake.sv
module accel_ctl_handshake
  import accel_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       wr_start,
  input  logic       wr_auto,
  input  logic       rd_ctl,
  input  logic       core_done,
  input  logic       core_ready,
  output ctl_state_t st
);

  logic launch_sw, launch_auto, launch;

  assign launch_sw   = wr_ctl & wr_start;
  assign launch_auto = core_done & st.auto_rs;
  assign launch      = launch_sw | launch_auto;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st.start   <= 1'b0;
      st.done    <= 1'b0;
      st.idle    <= 1'b1;
      st.ready   <= 1'b0;
      st.auto_rs <= 1'b0;
    end else begin
      // start: set by launch, cleared by the core's acceptance
      if (launch)          st.start <= 1'b1;
      else if (core_ready) st.start <= 1'b0;

      // done: event beats clear-on-read
      if (core_done)   st.done <= 1'b1;
      else if (rd_ctl) st.done <= 1'b0;

      // ready: pulse sets, next launch clears
      if (core_ready)  st.ready <= 1'b1;
      else if (launch) st.ready <= 1'b0;

      // idle: busy from launch until a done with nothing pending
      if (launch)                      st.idle <= 1'b0;
      else if (core_done && !st.start) st.idle <= 1'b1;

      if (wr_ctl) st.auto_rs <= wr_auto;
    end
  end

  assert_start_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_start) |=> st.start);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && !wr_ctl && !core_done) |=> !st.start);

  assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> st.done);

  assert_done_clear_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctl && !core_done) |=> !st.done);

  assert_idle_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_start) |=> !st.idle);

  assert_auto_relaunch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && st.auto_rs) |=> st.start);

endmodule

// File: rtl/accel_ctl_irq.sv
module accel_ctl_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_gie,
  input  logic              wr_ier,
  input  logic              wr_isr,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] evt,
  output logic              gie,
  output logic [NUM_CH-1:0] ier,
  output logic [NUM_CH-1:0] isr,
  output logic              irq
);

  logic [NUM_CH-1:0] set_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      ier <= '0;
    end else begin
      if (wr_gie) gie <= wbits[0];
      if (wr_ier) ier <= wbits;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      assign set_evt[c] = evt[c] & ier[c];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  isr[c] <= 1'b0;
        else if (set_evt[c])         isr[c] <= 1'b1;
        else if (wr_isr && wbits[c]) isr[c] <= ~isr[c];
      end

      assert_status_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt[c] |=> isr[c]);

      assert_masked_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt[c] && !ier[c] && !(wr_isr && wbits[c])) |=> $stable(isr[c]));

      assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_isr && wbits[c] && !set_evt[c]) |=> (isr[c] != $past(isr[c])));
    end
  endgenerate

  assign irq = gie & (|isr);

  assert_irq_follows_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && (|set_evt) && !wr_gie) |=> irq);

endmodule

// File: rtl/accel_ctl_param_bank.sv
module accel_ctl_param_bank #(
  parameter int ADDR_W  = 8,
  parameter int PARAM_W = 16,
  parameter int NUM     = 10,
  parameter int BASE    = 'h10,
  parameter int STRIDE  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PARAM_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_hit,
  output logic [PARAM_W-1:0] rd_val
);

  logic [PARAM_W-1:0] word [NUM];
  logic [NUM-1:0]     wr_sel;
  logic [NUM-1:0]     rd_sel;

  genvar i;
  generate
    for (i = 0; i < NUM; i++) begin : g_word
      localparam logic [ADDR_W-1:0] SLOT_OFS = ADDR_W'(BASE + i * STRIDE);

      assign wr_sel[i] = wr_en && (wr_addr == SLOT_OFS);
      assign rd_sel[i] = (rd_addr == SLOT_OFS);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         word[i] <= '0;
        else if (wr_sel[i]) word[i] <= wr_data;
      end

      assert_param_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SLOT_OFS) |=> (word[i] == $past(wr_data)));

      assert_param_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == SLOT_OFS) |=> $stable(word[i]));
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM; k++) begin
      if (rd_sel[k]) rd_val = word[k];
    end
  end

  assign rd_hit = |rd_sel;

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
  import accel_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PARAM_W    = 16,
  parameter int NUM_PARAMS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd_valid,
  output logic              core_start,
  input  logic              core_ready,
  input  logic              core_done,
  output logic              irq
);

  localparam int NUM_CH = 2;

  logic at_ctrl, at_gie, at_ier, at_isr;
  logic unused_wbits;

  assign at_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign at_gie  = (bus_addr == ADDR_W'(OFS_GIE));
  assign at_ier  = (bus_addr == ADDR_W'(OFS_IER));
  assign at_isr  = (bus_addr == ADDR_W'(OFS_ISR));
  assign unused_wbits = ^bus_wdata[DATA_W-1:PARAM_W];

  // Launch / done / idle / ready tracking
  ctl_state_t st;

  accel_ctl_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (bus_wr_en && at_ctrl),
    .wr_start   (bus_wdata[CB_START]),
    .wr_auto    (bus_wdata[CB_AUTO]),
    .rd_ctl     (bus_rd_en && at_ctrl),
    .core_done  (core_done),
    .core_ready (core_ready),
    .st         (st)
  );

  assign core_start = st.start;

  // Interrupt unit
  logic              gie;
  logic [NUM_CH-1:0] ier, isr, ev;

  always_comb begin
    ev           = '0;
    ev[CH_DONE]  = core_done;
    ev[CH_READY] = core_ready;
  end

  accel_ctl_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_gie (bus_wr_en && at_gie),
    .wr_ier (bus_wr_en && at_ier),
    .wr_isr (bus_wr_en && at_isr),
    .wbits  (bus_wdata[NUM_CH-1:0]),
    .evt    (ev),
    .gie    (gie),
    .ier    (ier),
    .isr    (isr),
    .irq    (irq)
  );

  // Parameter storage
  logic               p_hit;
  logic [PARAM_W-1:0] p_val;

  accel_ctl_param_bank #(
    .ADDR_W (ADDR_W),
    .PARAM_W(PARAM_W),
    .NUM    (NUM_PARAMS),
    .BASE   (PARAM_BASE),
    .STRIDE (PARAM_STRIDE)
  ) u_params (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr_en),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata[PARAM_W-1:0]),
    .rd_addr (bus_addr),
    .rd_hit  (p_hit),
    .rd_val  (p_val)
  );

  // Read mux and registered return path
  logic [DATA_W-1:0] rd_word;
  logic              rsvd;

  assign rsvd = !(at_ctrl || at_gie || at_ier || at_isr || p_hit);

  always_comb begin
    rd_word = '0;
    if (at_ctrl) begin
      rd_word[CB_START] = st.start;
      rd_word[CB_DONE]  = st.done;
      rd_word[CB_IDLE]  = st.idle;
      rd_word[CB_READY] = st.ready;
      rd_word[CB_AUTO]  = st.auto_rs;
    end else if (at_gie) begin
      rd_word[0] = gie;
    end else if (at_ier) begin
      rd_word[NUM_CH-1:0] = ier;
    end else if (at_isr) begin
      rd_word[NUM_CH-1:0] = isr;
    end else if (p_hit) begin
      rd_word[PARAM_W-1:0] = p_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_rd_valid <= 1'b0;
    end else begin
      bus_rd_valid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_word;
    end
  end

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rd_valid);

  assert_no_spurious_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rd_valid);

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && rsvd) |=> (bus_rdata == '0));

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gie);

endmodule

// File: tb/accel_ctl_regs_test.sv
module accel_ctl_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd_en = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rd_valid;
  logic        core_start;
  logic        core_ready = 1'b0;
  logic        core_done = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  accel_ctl_regs uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr_en    (bus_wr_en),
    .bus_wdata    (bus_wdata),
    .bus_rd_en    (bus_rd_en),
    .bus_rdata    (bus_rdata),
    .bus_rd_valid (bus_rd_valid),
    .core_start   (core_start),
    .core_ready   (core_ready),
    .core_done    (core_done),
    .irq          (irq)
  );

  // {offset, write data, expected read-back}
  localparam int NV = 15;
  localparam logic [71:0] VECS [NV] = '{
    {8'h10, 32'hABCD1234, 32'h0000_1234},
    {8'h18, 32'h0000FFFF, 32'h0000_FFFF},
    {8'h20, 32'h00000003, 32'h0000_0003},
    {8'h28, 32'h12345678, 32'h0000_5678},
    {8'h30, 32'h0000007F, 32'h0000_007F},
    {8'h38, 32'hFFFF0001, 32'h0000_0001},
    {8'h40, 32'h00000438, 32'h0000_0438},
    {8'h48, 32'h000000AA, 32'h0000_00AA},
    {8'h50, 32'h00000055, 32'h0000_0055},
    {8'h58, 32'h0000F00D, 32'h0000_F00D},
    {8'h14, 32'hFFFFFFFF, 32'h0000_0000},
    {8'h5C, 32'hFFFFFFFF, 32'h0000_0000},
    {8'h60, 32'hFFFFFFFF, 32'h0000_0000},
    {8'h04, 32'hFFFFFFFF, 32'h0000_0001},
    {8'h08, 32'hFFFFFFFF, 32'h0000_0003}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata; v = bus_rd_valid;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_read(a, d, v);
    check(req, d, exp);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); core_ready = 1'b1;
    @(negedge clk); core_ready = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    read_check("R1 ctrl", 8'h00, 32'h04);
    read_check("R1 gie", 8'h04, 32'h0);
    read_check("R1 ier", 8'h08, 32'h0);
    read_check("R1 isr", 8'h0C, 32'h0);
    read_check("R1 param", 8'h10, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 core_start", {31'b0, core_start}, 32'h0);

    // R13: valid one cycle after strobe, then low
    bus_read(8'h00, d, v);
    check("R13 valid", {31'b0, v}, 32'h1);
    @(negedge clk);
    check("R13 valid drops", {31'b0, bus_rd_valid}, 32'h0);

    // Single launch: R2, R4, R5, R3
    bus_write(8'h00, 32'h1);
    check("R2 start raised", {31'b0, core_start}, 32'h1);
    read_check("R4 idle low while busy", 8'h00, 32'h01);
    bus_write(8'h00, 32'h0);
    check("R2 write 0 ignored", {31'b0, core_start}, 32'h1);
    pulse_ready();
    check("R2 start cleared by handshake", {31'b0, core_start}, 32'h0);
    read_check("R5 ready set", 8'h00, 32'h08);
    pulse_done();
    read_check("R3 done visible, R4 idle back", 8'h00, 32'h0E);
    read_check("R3 cleared on read", 8'h00, 32'h0C);
    read_check("R8 disabled channels stay clear", 8'h0C, 32'h0);

    // Vector table: R7, R11, R12
    for (int i = 0; i < NV; i++) begin
      bus_write(VECS[i][71:64], VECS[i][63:32]);
      read_check("R7/R11/R12 vector", VECS[i][71:64], VECS[i][31:0]);
    end
    read_check("R12 reserved write left neighbour", 8'h10, 32'h1234);
    read_check("R12 reserved write left last word", 8'h58, 32'hF00D);

    // Interrupts: R8, R9, R10
    bus_write(8'h04, 32'h0);
    bus_write(8'h08, 32'h1);
    pulse_done();
    read_check("R8 done channel sets", 8'h0C, 32'h1);
    check("R10 gated by global enable", {31'b0, irq}, 32'h0);
    bus_write(8'h04, 32'h1);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    pulse_ready();
    read_check("R8 masked ready ignored", 8'h0C, 32'h1);
    bus_write(8'h0C, 32'h1);
    read_check("R9 toggle clears", 8'h0C, 32'h0);
    check("R10 irq drops", {31'b0, irq}, 32'h0);
    bus_write(8'h0C, 32'h2);
    read_check("R9 toggle sets", 8'h0C, 32'h2);
    check("R10 irq from ready bit", {31'b0, irq}, 32'h1);
    bus_write(8'h0C, 32'h0);
    read_check("R9 zero write no effect", 8'h0C, 32'h2);
    bus_write(8'h0C, 32'h2);
    pulse_done();
    read_check("R8 set again", 8'h0C, 32'h1);
    // toggle write and set event in the same cycle
    @(negedge clk);
    bus_addr = 8'h0C; bus_wdata = 32'h1; bus_wr_en = 1'b1; core_done = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; core_done = 1'b0;
    read_check("R9 set wins over toggle", 8'h0C, 32'h1);

    // Done pulse racing a read of the control word: R3
    bus_read(8'h00, d, v);
    read_check("R3 cleared before race", 8'h00, 32'h0C);
    @(negedge clk);
    bus_addr = 8'h00; bus_rd_en = 1'b1; core_done = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0; core_done = 1'b0;
    check("R3 racing read sees old value", bus_rdata, 32'h0C);
    read_check("R3 done survives racing read", 8'h00, 32'h0E);
    read_check("R3 then clears", 8'h00, 32'h0C);

    // Auto-relaunch: R6, R5, R4
    bus_write(8'h04, 32'h0);
    bus_write(8'h00, 32'h81);
    check("R6 launch with auto", {31'b0, core_start}, 32'h1);
    pulse_ready();
    check("R2 handshake clears", {31'b0, core_start}, 32'h0);
    pulse_done();
    check("R6 relaunch on done", {31'b0, core_start}, 32'h1);
    read_check("R6 ctrl after relaunch, R5 ready cleared", 8'h00, 32'h83);
    read_check("R6 ctrl after clear-on-read", 8'h00, 32'h81);
    pulse_ready();
    pulse_done();
    check("R6 second relaunch", {31'b0, core_start}, 32'h1);
    bus_write(8'h00, 32'h00);
    check("R2 write 0 keeps pending start", {31'b0, core_start}, 32'h1);
    pulse_ready();
    pulse_done();
    check("R6 no relaunch once cleared", {31'b0, core_start}, 32'h0);
    read_check("R4 idle after final done", 8'h00, 32'h0E);

    // Reset again mid-run: R1
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_check("R1 ctrl after reset", 8'h00, 32'h04);
    read_check("R1 param after reset", 8'h58, 32'h0);
    read_check("R1 isr after reset", 8'h0C, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule